// File: doc/BRIEF.md
# Tester Response Match Unit

This block sits in the compare path of a digital tester channel group. Each tester cycle is one frame of sub-cycle clock ticks. A pulse on `cyc_start` opens the frame and latches that frame's settings: the compare mode, the expected word, the care mask, the selected pin, the train pattern and length, and the strobe delay. The device outputs are registered once, at the programmed strobe tick. The comparison is made on the following tick, and its result is registered.

In word mode, every cared pin is compared in parallel against the expected word within the one frame. In train mode, a single chosen pin is followed across successive frames, and its bits are matched against a stored pattern of 1 to 16 bits. The search acts as a sliding window: any wrong bit sends the position back to the start.

A full match from either mode raises a branch request to the pattern sequencer, which can then change its flow straight away. The request stays up until the sequencer acknowledges it. A per-frame fail vector and a sticky fail flag report mismatches.

Top module: `trm_unit`

## Requirements
- R1: In word mode (`mode_sel`=0), after a compare `pin_fail` equals (sampled pins XOR `exp_word`) AND `care`. `fail_now` is the OR of those bits. `match` pulses for one clock exactly when no bit fails.
- R2: A pin whose `care` bit is 0 is never reported as failing, in either mode. In train mode, a masked selected pin counts as a correct bit.
- R3: The pins are sampled on the clock edge at which the tick count since `cyc_start` (0 on the first edge after it) equals `strobe_dly`. Values before and after that edge have no effect. The results are registered one edge later and hold until the next compare.
- R4: In train mode (`mode_sel`=1), bit k of the sequence on pin `pin_sel` is compared with `train_pat[k]`. `match` pulses on the compare in which the last bit of the train is correct.
- R5: In train mode, a wrong bit returns the position to 0. That same bit is not reused as position 0, and the search restarts on the next frame. After a match the position also returns to 0.
- R6: The `train_len` code n selects a train of n+1 bits, from 1 (code 0) to 16 (code 15).
- R7: In train mode, `pin_fail` has only bit `pin_sel` set, and only when that bit is cared and wrong. Otherwise it is all zero.
- R8: `sticky_fail` sets on any failing compare and stays set until `clr_sticky`. A failing compare in the same clock as `clr_sticky` leaves it set.
- R9: A match raises `br_req` on the same edge as the `match` pulse. `br_req` holds until `br_ack` is seen. Matches while `br_req` is high are ignored, including one in the acknowledging clock.
- R10: After reset, `pin_fail`, `fail_now`, `sticky_fail`, `match` and `br_req` are all 0, and the train position is 0.
- R11: A word-mode compare returns the train position to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-cycle tick clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Opens a frame and latches the settings below |
| mode_sel | input | 1 | 0 word compare, 1 train compare |
| exp_word | input | PINS | Expected pin values for word mode |
| care | input | PINS | Per-pin compare enable |
| pin_sel | input | $clog2(PINS) | Pin followed in train mode |
| train_pat | input | TRN | Expected train bits, position k at bit k |
| train_len | input | $clog2(TRN) | Train length minus one |
| strobe_dly | input | DLY_W | Strobe tick within the frame |
| dut_pins | input | PINS | Device outputs |
| clr_sticky | input | 1 | Clears the sticky fail flag |
| br_ack | input | 1 | Sequencer acknowledge of the branch request |
| pin_fail | output | PINS | Per-pin result of the latest compare |
| fail_now | output | 1 | Any failing pin in the latest compare |
| sticky_fail | output | 1 | Mismatch seen since the last clear |
| match | output | 1 | One-clock match pulse |
| br_req | output | 1 | Pending branch request |

## Verification
The hardest state to reach is a completed long train that meets a branch request still pending from an earlier match. Getting there takes 16 consecutive correct frames on one pin, followed by a match that must be dropped. The stimulus biases the selected pin toward the bit the reference model expects at its current position. It also withholds acknowledges for stretches, so the pending case occurs both in directed sequences and in random ones. Each frame surrounds the strobe tick with random pin values, so a sample taken on the wrong tick shows up as a mismatch.

// File: rtl/trm_pkg.sv
package trm_pkg;
  typedef enum logic {
    MODE_WORD  = 1'b0,
    MODE_TRAIN = 1'b1
  } trm_mode_e;
endpackage

// File: rtl/trm_strobe.sv
module trm_strobe
  import trm_pkg::*;
#(
  parameter int PINS  = 16,
  parameter int TRN   = 16,
  parameter int DLY_W = 4,
  localparam int SEL_W = $clog2(PINS),
  localparam int LEN_W = $clog2(TRN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_start,
  input  trm_mode_e        mode_i,
  input  logic [PINS-1:0]  exp_i,
  input  logic [PINS-1:0]  care_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [TRN-1:0]   pat_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic [PINS-1:0]  dut_i,
  output logic             smp_v,
  output trm_mode_e        mode_o,
  output logic [PINS-1:0]  exp_o,
  output logic [PINS-1:0]  care_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [TRN-1:0]   pat_o,
  output logic [LEN_W-1:0] len_o,
  output logic [PINS-1:0]  dut_o
);
  localparam logic [DLY_W-1:0] TICK_MAX = '1;

  logic [DLY_W-1:0] tick;
  logic [DLY_W-1:0] dly_q;
  logic             armed;

  // frame settings
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= MODE_WORD;
      exp_o  <= '0;
      care_o <= '0;
      sel_o  <= '0;
      pat_o  <= '0;
      len_o  <= '0;
      dly_q  <= '0;
    end else if (cyc_start) begin
      mode_o <= mode_i;
      exp_o  <= exp_i;
      care_o <= care_i;
      sel_o  <= sel_i;
      pat_o  <= pat_i;
      len_o  <= len_i;
      dly_q  <= dly_i;
    end
  end

  // tick counter and strobe capture
  always_ff @(posedge clk) begin
    if (rst) begin
      tick  <= '0;
      armed <= 1'b0;
      smp_v <= 1'b0;
      dut_o <= '0;
    end else if (cyc_start) begin
      tick  <= '0;
      armed <= 1'b1;
      smp_v <= 1'b0;
    end else begin
      if (tick != TICK_MAX) tick <= tick + 1'b1;
      if (armed && tick == dly_q) begin
        dut_o <= dut_i;
        armed <= 1'b0;
        smp_v <= 1'b1;
      end else begin
        smp_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/trm_compare.sv
module trm_compare
  import trm_pkg::*;
#(
  parameter int PINS = 16,
  parameter int TRN  = 16,
  localparam int SEL_W = $clog2(PINS),
  localparam int LEN_W = $clog2(TRN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_v,
  input  trm_mode_e        mode,
  input  logic [PINS-1:0]  exp_w,
  input  logic [PINS-1:0]  care,
  input  logic [SEL_W-1:0] sel,
  input  logic [TRN-1:0]   pat,
  input  logic [LEN_W-1:0] len,
  input  logic [PINS-1:0]  dut,
  output logic [PINS-1:0]  diff,
  output logic             hit
);
  logic [LEN_W-1:0] pos;
  logic [PINS-1:0]  word_diff;
  logic [PINS-1:0]  train_diff;
  logic             t_ok;
  logic             t_last;

  assign word_diff = (dut ^ exp_w) & care;
  assign t_ok      = !care[sel] || (dut[sel] == pat[pos]);
  assign t_last    = (pos == len);

  for (genvar g = 0; g < PINS; g++) begin : g_tdiff
    assign train_diff[g] = (sel == SEL_W'(g)) && !t_ok;
  end

  always_comb begin
    if (mode == MODE_TRAIN) begin
      diff = train_diff;
      hit  = t_ok && t_last;
    end else begin
      diff = word_diff;
      hit  = ~|word_diff;
    end
  end

  // sliding train position
  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (smp_v) begin
      if (mode != MODE_TRAIN || !t_ok || t_last) pos <= '0;
      else                                       pos <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/trm_result.sv
module trm_result #(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            smp_v,
  input  logic [PINS-1:0] diff,
  input  logic            hit,
  input  logic            clr_sticky,
  input  logic            br_ack,
  output logic [PINS-1:0] pin_fail,
  output logic            fail_now,
  output logic            sticky_fail,
  output logic            match,
  output logic            br_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_fail <= '0;
      fail_now <= 1'b0;
      match    <= 1'b0;
    end else begin
      match <= smp_v && hit;
      if (smp_v) begin
        pin_fail <= diff;
        fail_now <= |diff;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  sticky_fail <= 1'b0;
    else if (smp_v && |diff)  sticky_fail <= 1'b1;
    else if (clr_sticky)      sticky_fail <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                br_req <= 1'b0;
    else if (br_req)        br_req <= !br_ack;
    else if (smp_v && hit)  br_req <= 1'b1;
  end
endmodule

// File: rtl/trm_unit.sv
module trm_unit
  import trm_pkg::*;
#(
  parameter int PINS  = 16,
  parameter int TRN   = 16,
  parameter int DLY_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cyc_start,
  input  logic                     mode_sel,
  input  logic [PINS-1:0]          exp_word,
  input  logic [PINS-1:0]          care,
  input  logic [$clog2(PINS)-1:0]  pin_sel,
  input  logic [TRN-1:0]           train_pat,
  input  logic [$clog2(TRN)-1:0]   train_len,
  input  logic [DLY_W-1:0]         strobe_dly,
  input  logic [PINS-1:0]          dut_pins,
  input  logic                     clr_sticky,
  input  logic                     br_ack,
  output logic [PINS-1:0]          pin_fail,
  output logic                     fail_now,
  output logic                     sticky_fail,
  output logic                     match,
  output logic                     br_req
);
  localparam int SEL_W = $clog2(PINS);
  localparam int LEN_W = $clog2(TRN);

  trm_mode_e        mode_q;
  logic [PINS-1:0]  exp_q, care_q, dut_q, diff;
  logic [SEL_W-1:0] sel_q;
  logic [TRN-1:0]   pat_q;
  logic [LEN_W-1:0] len_q;
  logic             smp_v, hit;

  trm_strobe #(.PINS(PINS), .TRN(TRN), .DLY_W(DLY_W)) u_strobe (
    .clk(clk), .rst(rst), .cyc_start(cyc_start),
    .mode_i(trm_mode_e'(mode_sel)), .exp_i(exp_word), .care_i(care),
    .sel_i(pin_sel), .pat_i(train_pat), .len_i(train_len),
    .dly_i(strobe_dly), .dut_i(dut_pins),
    .smp_v(smp_v), .mode_o(mode_q), .exp_o(exp_q), .care_o(care_q),
    .sel_o(sel_q), .pat_o(pat_q), .len_o(len_q), .dut_o(dut_q)
  );

  trm_compare #(.PINS(PINS), .TRN(TRN)) u_compare (
    .clk(clk), .rst(rst), .smp_v(smp_v), .mode(mode_q),
    .exp_w(exp_q), .care(care_q), .sel(sel_q), .pat(pat_q),
    .len(len_q), .dut(dut_q), .diff(diff), .hit(hit)
  );

  trm_result #(.PINS(PINS)) u_result (
    .clk(clk), .rst(rst), .smp_v(smp_v), .diff(diff), .hit(hit),
    .clr_sticky(clr_sticky), .br_ack(br_ack),
    .pin_fail(pin_fail), .fail_now(fail_now), .sticky_fail(sticky_fail),
    .match(match), .br_req(br_req)
  );
endmodule

// File: rtl/trm_unit_chk.sv
module trm_unit_chk (
  input logic clk,
  input logic rst,
  input logic match,
  input logic fail_now,
  input logic sticky_fail,
  input logic clr_sticky,
  input logic br_req,
  input logic br_ack
);
  AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (rst) match |=> !match); // R4
  AST_MATCH_NO_FAIL: assert property (@(posedge clk) disable iff (rst) match |-> !fail_now); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst) (br_req && !br_ack) |=> br_req); // R9
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst) (br_req && br_ack) |=> !br_req); // R9
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst) (sticky_fail && !clr_sticky) |=> sticky_fail); // R8
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst) $rose(fail_now) |-> sticky_fail); // R8
  AST_RESET_CLEAN: assert property (@(posedge clk) $past(rst) |-> (!match && !br_req && !sticky_fail && !fail_now)); // R10
endmodule

bind trm_unit trm_unit_chk u_chk (
  .clk(clk), .rst(rst), .match(match), .fail_now(fail_now),
  .sticky_fail(sticky_fail), .clr_sticky(clr_sticky),
  .br_req(br_req), .br_ack(br_ack)
);

// File: tb/trm_unit_test.sv
module trm_unit_test;
  localparam int PINS = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 1'b0, mode_sel = 1'b0, clr_sticky = 1'b0, br_ack = 1'b0;
  logic [15:0] exp_word = '0, care = '0, train_pat = '0, dut_pins = '0;
  logic [3:0]  pin_sel = '0, train_len = '0, strobe_dly = '0;
  logic [15:0] pin_fail;
  logic fail_now, sticky_fail, match, br_req;

  int checks = 0, errors = 0, mcount = 0;
  int m_pos = 0;
  bit m_pend = 0, m_sticky = 0;

  always #5 clk = ~clk;

  trm_unit uut (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .mode_sel(mode_sel),
    .exp_word(exp_word), .care(care), .pin_sel(pin_sel), .train_pat(train_pat),
    .train_len(train_len), .strobe_dly(strobe_dly), .dut_pins(dut_pins),
    .clr_sticky(clr_sticky), .br_ack(br_ack), .pin_fail(pin_fail),
    .fail_now(fail_now), .sticky_fail(sticky_fail), .match(match), .br_req(br_req)
  );

  always @(negedge clk) if (match) mcount++;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] word_diff(logic [15:0] v, logic [15:0] e, logic [15:0] c);
    return (v ^ e) & c;
  endfunction

  // one frame; model updated from the requirements, then outputs compared
  task automatic frame(input string tag, input bit md, input logic [15:0] e,
                       input logic [15:0] c, input logic [3:0] sel,
                       input logic [15:0] pat, input logic [3:0] len,
                       input logic [3:0] dly, input logic [15:0] val,
                       input logic [15:0] pre, input logic [15:0] post,
                       input bit clr, input bit ack);
    logic [15:0] d;
    bit hit, ok;
    @(negedge clk);
    cyc_start = 1; mode_sel = md; exp_word = e; care = c; pin_sel = sel;
    train_pat = pat; train_len = len; strobe_dly = dly; dut_pins = pre;
    clr_sticky = clr; br_ack = ack; mcount = 0;
    for (int k = 0; k < 19; k++) begin
      @(negedge clk);
      if (k == 0) begin cyc_start = 0; clr_sticky = 0; br_ack = 0; end
      if (k == int'(dly)) dut_pins = val;
      if (k == int'(dly) + 1) dut_pins = post;
    end
    if (ack) m_pend = 0;
    if (clr) m_sticky = 0;
    if (md) begin
      ok = !c[sel] || (val[sel] == pat[m_pos]);
      d = ok ? 16'h0 : (16'h1 << sel);
      hit = ok && (m_pos == int'(len));
      m_pos = (!ok || hit) ? 0 : m_pos + 1;
    end else begin
      d = word_diff(val, e, c);
      hit = (d == 0);
      m_pos = 0;
    end
    if (d != 0) m_sticky = 1;
    if (hit && !m_pend) m_pend = 1;
    chk(pin_fail == d, tag, "pin_fail", pin_fail, d);
    chk(fail_now == (d != 0), tag, "fail_now", fail_now, (d != 0));
    chk(mcount == int'(hit), tag, "match pulses", mcount, hit);
    chk(sticky_fail == m_sticky, "R8", "sticky_fail", sticky_fail, m_sticky);
    chk(br_req == m_pend, "R9", "br_req", br_req, m_pend);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] pat, val;
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(pin_fail == 0 && !fail_now && !sticky_fail && !match && !br_req, "R10",
        "outputs after reset", {pin_fail, fail_now, sticky_fail, match, br_req}, 0);

    // R1 word match then mismatch; R3 strobe at both ends of the delay range
    frame("R1", 0, 16'hA5C3, 16'hFFFF, 0, 0, 0, 4'd5, 16'hA5C3, 16'h0, 16'hFFFF, 0, 1);
    frame("R1", 0, 16'hA5C3, 16'hFFFF, 0, 0, 0, 4'd5, 16'hA5C2, 16'h0, 16'h0, 0, 1);
    frame("R3", 0, 16'h1234, 16'hFFFF, 0, 0, 0, 4'd0, 16'h1234, 16'hEDCB, 16'hEDCB, 1, 0);
    frame("R3", 0, 16'h1234, 16'hFFFF, 0, 0, 0, 4'd15, 16'h1234, 16'hEDCB, 16'hEDCB, 0, 0);
    // R2 all pins masked: wrong values do not fail
    frame("R2", 0, 16'h0000, 16'h0000, 0, 0, 0, 4'd3, 16'hFFFF, 16'h0, 16'h0, 1, 1);
    // R9 match while pending is ignored, request still held
    frame("R9", 0, 16'h00FF, 16'hFFFF, 0, 0, 0, 4'd2, 16'h00FF, 16'h0, 16'h0, 0, 0);
    // R6 train of 16 bits on pin 7
    pat = 16'hB3E1;
    for (int i = 0; i < 16; i++) begin
      val = 16'h0; val[7] = pat[i];
      frame("R6", 1, 0, 16'hFFFF, 4'd7, pat, 4'd15, 4'($urandom_range(0, 15)), val, ~val, ~val, 0, i == 0);
    end
    // R6 one-bit train
    frame("R6", 1, 0, 16'hFFFF, 4'd3, 16'h0001, 4'd0, 4'd4, 16'h0008, 16'h0, 16'h0, 0, 1);
    // R5 sliding restart: pattern 0,1,1 fed 0,0,1,1,0,1,1
    foreach (val[i]) begin end
    for (int i = 0; i < 7; i++) begin
      logic [6:0] seq = 7'b1101100;
      val = {15'h0, seq[i]};
      frame("R5", 1, 0, 16'hFFFF, 4'd0, 16'h0006, 4'd2, 4'd1, val, ~val, ~val, 0, 1);
    end
    // R7 train mismatch marks only the selected pin; R2 masked selected pin counts as correct
    frame("R7", 1, 0, 16'hFFFF, 4'd12, 16'h0000, 4'd3, 4'd6, 16'hFFFF, 16'h0, 16'h0, 1, 1);
    frame("R2", 1, 0, 16'hEFFF, 4'd12, 16'h0000, 4'd0, 4'd6, 16'hFFFF, 16'h0, 16'h0, 1, 1);
    // R11 word compare mid-train resets the position
    frame("R4", 1, 0, 16'hFFFF, 4'd1, 16'h0003, 4'd1, 4'd2, 16'h0002, 16'h0, 16'h0, 0, 1);
    frame("R11", 0, 16'h0, 16'hFFFF, 0, 0, 0, 4'd2, 16'h0, 16'h0, 16'h0, 0, 1);
    frame("R11", 1, 0, 16'hFFFF, 4'd1, 16'h0003, 4'd1, 4'd2, 16'h0002, 16'h0, 16'h0, 0, 1);
    // R8 clear in same frame as failure keeps sticky set
    frame("R8", 0, 16'h0, 16'hFFFF, 0, 0, 0, 4'd1, 16'h0001, 16'h0, 16'h0, 1, 1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      bit md = 1'($urandom_range(0, 1));
      logic [15:0] e = 16'($urandom), c = 16'($urandom) | 16'hF0F0;
      logic [3:0] sel = 4'($urandom), len = 4'($urandom_range(0, 5));
      logic [15:0] tp = 16'($urandom);
      if ($urandom_range(0, 7) == 0) len = 4'd15;
      if (md) begin
        val = 16'($urandom);
        if (m_pos <= int'(len) && $urandom_range(0, 9) < 8) val[sel] = tp[m_pos];
        tp = 16'h5A3C; // hold pattern steady so trains can complete
        if (m_pos <= int'(len)) val[sel] = ($urandom_range(0, 9) < 8) ? tp[m_pos] : ~tp[m_pos];
      end else begin
        val = e ^ (($urandom_range(0, 1) == 1) ? 16'($urandom) & 16'($urandom) : 16'h0);
      end
      frame(md ? "R4" : "R1", md, e, c, sel, tp, md ? 4'(len) : 4'd0,
            4'($urandom_range(0, 15)), val, 16'($urandom), 16'($urandom),
            $urandom_range(0, 7) == 0, $urandom_range(0, 3) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule